// File: doc/BRIEF.md
# Paged Write Buffer with Timed Commit

This block is the storage side of a small byte-wide non-volatile memory model. A serial front end, which handles framing and condition detection, hands it one event per cycle: an address byte, a data byte, a stop, or a read request. The block keeps the word pointer and a one-page staging buffer. It then commits the staged bytes to a 256 x 8 array in a single self-timed write cycle. During that cycle a busy flag is raised and every input is locked out.

The pointer advances in two ways. A data byte moves only the three low bits of the pointer, so writes stay inside one 8-byte page and wrap around within it. A read moves the whole 8-bit pointer, so sequential reads walk through the full array and wrap from the last byte to the first. A write-protect input, sampled when the stop arrives, can cancel the commit. Inside the write cycle the buffered slots are copied into the array one per clock, through a single write port, so the array maps onto one block RAM.

Top module: `pagewr_store`

## Requirements
- R1: After synchronous reset, busy and rd_valid are low, the pointer is 0 and every array byte reads as 0x00.
- R2: An address strobe loads bus_byte into the pointer; a following read returns the byte stored at that location.
- R3: A data strobe stores bus_byte into page slot pointer[2:0]. It then increments only pointer[2:0], wrapping from 7 to 0, while pointer[7:3] stays fixed.
- R4: When more than 8 data bytes arrive before a stop, each slot holds the last byte written to it, and that byte is what reaches the array.
- R5: At commit, only the slots that received data since the last address strobe or commit are written. The other bytes of the page keep their old values.
- R6: A stop with at least one buffered byte and wp_in low raises busy on the next cycle. Busy stays high for exactly WRITE_CYCLES cycles, and the new data is readable once busy is low.
- R7: While busy is high, the address, data, stop and read strobes have no effect: rd_valid stays low, the pointer and the buffer do not change, and no second write cycle follows.
- R8: A stop while wp_in is high starts no write cycle (busy stays low), leaves the array unchanged and discards the buffered bytes.
- R9: A stop with no buffered data starts no write cycle; busy stays low.
- R10: A read strobe presents the byte at the pointer on rd_data with rd_valid high in the next cycle. It then increments the full 8-bit pointer, so 0xFF is followed by 0x00.
- R11: An address strobe discards any buffered bytes that have not been committed, so a later stop writes only data received after that strobe.
- R12: When strobes coincide, the priority is address, then data, then stop, then read, and only the winning strobe takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_in | input | 1 | Write protect, sampled with the stop strobe |
| addr_stb | input | 1 | bus_byte is a word address |
| data_stb | input | 1 | bus_byte is a write data byte |
| stop_stb | input | 1 | Stop condition seen by the front end |
| rd_stb | input | 1 | Request the next sequential read byte |
| bus_byte | input | 8 | Byte delivered by the front end |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | rd_data is valid this cycle |
| busy | output | 1 | Internal write cycle in progress |

## Verification
A wrong pointer shows up on the very next read: rd_data comes from a neighbouring location. A wrong page wrap only appears once a commit has ended and the page is read back. Errors in the slot mask or in the buffer stay hidden for a whole write cycle, then surface as a stale byte or a clobbered byte when the page is read. A miscounted timer or a lockout that leaks shows up at once as a busy pulse of the wrong length, an rd_valid during busy, or a pointer that has moved by the next read.

// File: rtl/pagewr_pkg.sv
package pagewr_pkg;
  typedef enum logic [1:0] {
    PTR_HOLD,
    PTR_LOAD,
    PTR_PAGE_INC,
    PTR_FULL_INC
  } ptr_op_e;
endpackage

// File: rtl/pagewr_ptr.sv
module pagewr_ptr
  import pagewr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ptr_op_e           op,
  input  logic [ADDR_W-1:0] ld_val,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else begin
      case (op)
        PTR_LOAD:     ptr <= ld_val;
        PTR_PAGE_INC: ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
        PTR_FULL_INC: ptr <= ptr + 1'b1;
        default:      ptr <= ptr;
      endcase
    end
  end

  // R3: the in-page step wraps the low bits and keeps the page number
  p_page_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (op == PTR_PAGE_INC && (&ptr[PAGE_W-1:0])) |=>
      (ptr[PAGE_W-1:0] == '0) && $stable(ptr[ADDR_W-1:PAGE_W]));

  // R10: a sequential read past the top of the array comes back to zero
  p_array_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    (op == PTR_FULL_INC && (&ptr)) |=> (ptr == '0));
endmodule

// File: rtl/pagewr_pagebuf.sv
module pagewr_pagebuf #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [PAGE_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              clear,
  input  logic [PAGE_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_byte,
  output logic              rd_slot_valid,
  output logic              any_valid
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_mask;
  logic [PAGE_BYTES-1:0] wr_hot;

  assign wr_hot = PAGE_BYTES'(1) << wr_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_mask <= '0;
    end else if (clear) begin
      valid_mask <= '0;
    end else if (wr) begin
      valid_mask <= valid_mask | wr_hot;
    end
  end

  generate
    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr && !clear && wr_slot == PAGE_W'(s)) begin
          slot_data[s] <= wr_byte;
        end
      end
    end
  endgenerate

  assign rd_byte       = slot_data[rd_slot];
  assign rd_slot_valid = valid_mask[rd_slot];
  assign any_valid     = |valid_mask;

  // R5: a received byte marks its slot for the commit
  p_mark_slot_r5: assert property (@(posedge clk) disable iff (rst)
    (wr && !clear) |=> |(valid_mask & $past(wr_hot)));

  // R11: a clear leaves no slot pending
  p_clear_all_r11: assert property (@(posedge clk) disable iff (rst)
    clear |=> (valid_mask == '0));
endmodule

// File: rtl/pagewr_commit.sv
module pagewr_commit #(
  parameter int unsigned PAGE_W       = 3,
  parameter int unsigned WRITE_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              slot_en,
  output logic [PAGE_W-1:0] slot_idx,
  output logic              done
);
  localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
  localparam int unsigned EFF_CYCLES = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES + 1;
  localparam int unsigned CNT_W      = $clog2(EFF_CYCLES + 1);
  localparam int unsigned RUN_W      = $clog2(EFF_CYCLES + 2);

  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W:0]   slot_q;

  assign slot_en  = busy && (slot_q < (PAGE_W+1)'(PAGE_BYTES));
  assign slot_idx = slot_q[PAGE_W-1:0];
  assign done     = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      slot_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt    <= CNT_W'(EFF_CYCLES - 1);
      slot_q <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
      if (slot_en) slot_q <= slot_q + 1'b1;
    end
  end

  // checker state: length of the current busy run
  logic [RUN_W-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  // R6: every write cycle lasts exactly the configured length
  p_busy_len_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == RUN_W'(EFF_CYCLES)));

  // R7: the front gate never asks for a commit while one is running
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R5: all slots have been visited before the cycle ends
  p_slots_done_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (slot_q == (PAGE_W+1)'(PAGE_BYTES)));
endmodule

// File: rtl/pagewr_array.sv
module pagewr_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end

  // R7: commit writes and reads never share a cycle
  p_port_excl_r7: assert property (@(posedge clk) disable iff (rst)
    we |-> !re);
endmodule

// File: rtl/pagewr_store.sv
module pagewr_store
  import pagewr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PAGE_W       = 3,
  parameter int unsigned WRITE_CYCLES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_in,
  input  logic              addr_stb,
  input  logic              data_stb,
  input  logic              stop_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] bus_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy
);
  logic              accept;
  logic              addr_go, data_go, stop_go, rd_go;
  logic              commit_start, commit_done, buf_clear;
  logic              slot_en, slot_valid, any_valid, arr_we;
  logic [PAGE_W-1:0] slot_idx;
  logic [DATA_W-1:0] slot_byte;
  logic [ADDR_W-1:0] ptr;
  ptr_op_e           ptr_op;

  assign accept  = !busy;
  assign addr_go = accept && addr_stb;
  assign data_go = accept && data_stb && !addr_stb;
  assign stop_go = accept && stop_stb && !addr_stb && !data_stb;
  assign rd_go   = accept && rd_stb && !addr_stb && !data_stb && !stop_stb;

  assign commit_start = stop_go && any_valid && !wp_in;
  assign buf_clear    = addr_go || (stop_go && !commit_start) || commit_done;

  always_comb begin
    if (addr_go)      ptr_op = PTR_LOAD;
    else if (data_go) ptr_op = PTR_PAGE_INC;
    else if (rd_go)   ptr_op = PTR_FULL_INC;
    else              ptr_op = PTR_HOLD;
  end

  pagewr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst(rst), .op(ptr_op), .ld_val(bus_byte), .ptr(ptr)
  );

  pagewr_pagebuf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst(rst),
    .wr(data_go), .wr_slot(ptr[PAGE_W-1:0]), .wr_byte(bus_byte[DATA_W-1:0]),
    .clear(buf_clear),
    .rd_slot(slot_idx), .rd_byte(slot_byte), .rd_slot_valid(slot_valid),
    .any_valid(any_valid)
  );

  pagewr_commit #(.PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_commit (
    .clk(clk), .rst(rst), .start(commit_start), .busy(busy),
    .slot_en(slot_en), .slot_idx(slot_idx), .done(commit_done)
  );

  assign arr_we = slot_en && slot_valid;

  pagewr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst(rst),
    .we(arr_we), .waddr({ptr[ADDR_W-1:PAGE_W], slot_idx}), .wdata(slot_byte),
    .re(rd_go), .raddr(ptr), .rdata(rd_data), .rvalid(rd_valid)
  );

  // R8: a protected stop never opens a write cycle
  p_wp_block_r8: assert property (@(posedge clk) disable iff (rst)
    (stop_stb && wp_in && !busy) |=> !busy);

  // R9: a stop with nothing buffered leaves the block idle
  p_empty_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (stop_stb && !any_valid && !busy) |=> !busy);

  // R7: the pointer is frozen for the whole write cycle
  p_ptr_locked_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ptr));

  // R7: reads asked for during busy produce nothing
  p_rd_locked_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && busy) |=> !rd_valid);

  // R10: an accepted read is answered on the next cycle
  p_rd_answer_r10: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> rd_valid);
endmodule

// File: tb/pagewr_store_tb.sv
module pagewr_store_tb;
  localparam int WCYC = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wp_in = 1'b0;
  logic       addr_stb = 1'b0, data_stb = 1'b0, stop_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] bus_byte = '0;
  logic [7:0] rd_data;
  logic       rd_valid, busy;

  int checks = 0;
  int failures = 0;

  logic [7:0] mem_m [256];
  logic [7:0] buf_m [8];
  logic [7:0] mask_m;
  logic [7:0] ptr_m;

  always #2.5 clk = ~clk;

  pagewr_store #(.WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rst(rst), .wp_in(wp_in),
    .addr_stb(addr_stb), .data_stb(data_stb), .stop_stb(stop_stb), .rd_stb(rd_stb),
    .bus_byte(bus_byte), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
  );

  function automatic logic [7:0] page_step(input logic [7:0] p);
    return {p[7:3], p[2:0] + 3'd1};
  endfunction

  function automatic logic [7:0] slot_addr(input logic [7:0] p, input int s);
    return {p[7:3], 3'(s)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_addr(input logic [7:0] a);
    @(negedge clk); addr_stb = 1'b1; bus_byte = a;
    @(negedge clk); addr_stb = 1'b0;
    ptr_m = a; mask_m = '0;
  endtask

  task automatic do_data(input logic [7:0] d);
    @(negedge clk); data_stb = 1'b1; bus_byte = d;
    @(negedge clk); data_stb = 1'b0;
    buf_m[ptr_m[2:0]] = d; mask_m[ptr_m[2:0]] = 1'b1;
    ptr_m = page_step(ptr_m);
  endtask

  task automatic do_read(input string req);
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk(rd_valid === 1'b1, req, rd_valid, 1);
    chk(rd_data === mem_m[ptr_m], req, rd_data, mem_m[ptr_m]);
    ptr_m = ptr_m + 8'd1;
  endtask

  task automatic do_stop(input bit wp, input bit poke);
    bit    commit;
    int    n;
    string req;
    commit = (mask_m != 0) && !wp;
    req = commit ? "R6" : (wp ? "R8" : "R9");
    @(negedge clk); stop_stb = 1'b1; wp_in = wp;
    @(negedge clk); stop_stb = 1'b0; wp_in = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (poke && n == 2) begin
        addr_stb = 1'b1; data_stb = 1'b1; stop_stb = 1'b1; rd_stb = 1'b1;
        bus_byte = 8'($urandom);
      end
      if (poke && n == 3) begin
        addr_stb = 1'b0; data_stb = 1'b0; stop_stb = 1'b0; rd_stb = 1'b0;
        chk(rd_valid === 1'b0, "R7 read during busy", rd_valid, 0);
      end
      @(negedge clk);
    end
    chk(n == (commit ? WCYC : 0), req, n, commit ? WCYC : 0);
    @(negedge clk);
    chk(busy === 1'b0, "R7 no second cycle", busy, 0);
    if (commit) begin
      for (int s = 0; s < 8; s++)
        if (mask_m[s]) mem_m[slot_addr(ptr_m, s)] = buf_m[s];
    end
    mask_m = '0;
  endtask

  task automatic read_page(input logic [7:0] base, input string req);
    do_addr({base[7:3], 3'd0});
    for (int i = 0; i < 8; i++) do_read(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R6 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem_m[i] = '0;
    mask_m = '0; ptr_m = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(rd_valid === 1'b0, "R1 rd_valid", rd_valid, 0);
    do_read("R1 pointer zero");

    // R2 address load then read
    do_addr(8'h40);
    do_read("R2");

    // R3 in-page wrap: slots 5,6,7,0 of page 0x30
    do_addr(8'h35);
    for (int i = 0; i < 4; i++) do_data(8'hA0 + 8'(i));
    do_stop(1'b0, 1'b0);
    do_read("R3 pointer after wrap");
    read_page(8'h30, "R3");

    // R4 eleven bytes into page 0x80
    do_addr(8'h80);
    for (int i = 0; i < 11; i++) do_data(8'h10 + 8'(i));
    do_stop(1'b0, 1'b0);
    read_page(8'h80, "R4");

    // R5 fill page 0x90, then partial update of slots 2,3
    do_addr(8'h90);
    for (int i = 0; i < 8; i++) do_data(8'h50 + 8'(i));
    do_stop(1'b0, 1'b0);
    do_addr(8'h92);
    do_data(8'hE2); do_data(8'hE3);
    do_stop(1'b0, 1'b0);
    read_page(8'h90, "R5");

    // R8 protected stop
    do_addr(8'h90);
    for (int i = 0; i < 3; i++) do_data(8'hCC);
    do_stop(1'b1, 1'b0);
    read_page(8'h90, "R8");

    // R9 stop without data
    do_addr(8'hA0);
    do_stop(1'b0, 1'b0);

    // R11 second address drops pending bytes
    do_addr(8'hB0);
    do_data(8'h77); do_data(8'h78);
    do_addr(8'hC0);
    do_data(8'h99);
    do_stop(1'b0, 1'b0);
    read_page(8'hB0, "R11");
    read_page(8'hC0, "R11");

    // R7 strobes during busy are ignored
    do_addr(8'hD3);
    do_data(8'h3C);
    do_stop(1'b0, 1'b1);
    do_read("R7 pointer kept");
    read_page(8'hD0, "R7");

    // R10 sequential read across the top of the array
    do_addr(8'hFE);
    for (int i = 0; i < 4; i++) do_read("R10");

    // R12 address wins over a simultaneous data strobe
    @(negedge clk); addr_stb = 1'b1; data_stb = 1'b1; bus_byte = 8'h44;
    @(negedge clk); addr_stb = 1'b0; data_stb = 1'b0;
    ptr_m = 8'h44; mask_m = '0;
    do_stop(1'b0, 1'b0);
    do_read("R12");

    // random transactions
    for (int it = 0; it < 30; it++) begin
      logic [7:0] a;
      int         nb;
      bit         wp;
      a  = 8'($urandom);
      nb = int'($urandom % 13);
      wp = (($urandom % 4) == 0);
      do_addr(a);
      for (int k = 0; k < nb; k++) do_data(8'($urandom));
      do_stop(wp, (it % 5) == 0);
      do_read("R10 random");
      read_page(a, (nb > 8) ? "R4 random" : "R5 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule